// File: doc/BRIEF.md
# Automatic Echo Loop Controller

This block sits between an asynchronous receiver and the transmit side of a serial port. The receiver hands it whole characters, together with a break flag and a start-bit strobe. In normal operation the block is the transmit path. The CPU writes a transmit holding register, and a shift path sends each character as one low start bit, the data bits LSB first and one high stop bit. Each bit lasts one period of the transmit bit tick.

The block enters echo when three conditions hold: the port is in asynchronous mode, the two-bit submode selector is `01`, and the receiver is enabled. In echo every assembled character is copied into the holding register and sent straight back out. The shift path is then timed by the receive bit tick. CPU writes to the transmitter are blocked, the transmitter-ready flag is forced high and the transmit-enable command has no effect. A break is echoed only once, as a single all-zero character. After that the line idles high until the receiver reports a new valid start bit.

Received characters still reach the CPU through a receive holding register with a ready flag, in every mode. A combined status output shows the data-set-change input ORed with "transmitter empty". In echo it shows only the data-set-change input.

Top module: `echo_loop_ctl`

## Requirements
- R1: After reset `txd` is 1, `rx_rdy` is 0, and `tx_rdy` and `txemt_dschg` are 0 while `tx_en` and `dset_chg` are 0.
- R2: Echo is active only when `sync_mode`=0, `submode`=2'b01 and `rx_en`=1. Outside echo a received character is never retransmitted.
- R3: In echo each received character goes out on `txd` as one start bit (0), DATA_BITS data bits LSB first and one stop bit (1). The frame starts on the first selected tick after the character arrives.
- R4: Each transmitted bit lasts one period of `rxc_tick` while echo is active, and one period of `txc_tick` otherwise.
- R5: In echo the transmitter runs whatever the value of `tx_en`.
- R6: In echo `tx_rdy` is 1, and a pulse on `wr_strobe` puts nothing on `txd`.
- R7: A break character (`rx_break`=1) is echoed as an all-zero frame the first time it arrives. Further break characters are not echoed until a pulse on `rx_start`, after which characters are echoed again.
- R8: `txemt_dschg` equals `dset_chg` in echo. Otherwise it is `dset_chg` OR (`tx_en` AND holding register empty AND shifter idle).
- R9: Each `rx_valid` pulse with `rx_en`=1 loads `rhr_data` and sets `rx_rdy` in every mode. `rd_strobe` clears `rx_rdy`, and so does `rx_en`=0.
- R10: Outside echo, a `wr_strobe` with `tx_en`=1 while `tx_rdy`=1 loads the holding register. `tx_rdy` drops on the next cycle and the character is sent on `txd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sync_mode | input | 1 | 1 = synchronous major mode (echo never applies) |
| submode | input | 2 | Operating submode; 2'b01 selects echo in async mode |
| rx_en | input | 1 | Receiver enable |
| tx_en | input | 1 | Transmit enable command |
| rxc_tick | input | 1 | One-cycle pulse per receive bit time |
| txc_tick | input | 1 | One-cycle pulse per transmit bit time |
| rx_valid | input | 1 | Receiver has assembled a character |
| rx_data | input | DATA_BITS | Assembled character |
| rx_break | input | 1 | The character is a break (all zeros, stop sampled low) |
| rx_start | input | 1 | Receiver detected a valid start bit |
| rd_strobe | input | 1 | CPU read of the receive holding register |
| rhr_data | output | DATA_BITS | Receive holding register |
| rx_rdy | output | 1 | Receive holding register holds unread data |
| wr_strobe | input | 1 | CPU write to the transmit holding register |
| wr_data | input | DATA_BITS | CPU transmit character |
| dset_chg | input | 1 | Data-set-change condition from the modem status logic |
| tx_rdy | output | 1 | Transmit holding register can accept a character |
| txemt_dschg | output | 1 | Combined transmitter-empty / data-set-change status |
| txd | output | 1 | Serial transmit line, high when idle |

## Verification
The assertions assume that `rxc_tick` and `txc_tick` are single-cycle pulses at least two clocks apart. They also assume that `rx_valid` is one cycle long and that `rx_start` never coincides with `rx_valid`, which is how a real receiver spaces its strobes. The stimulus generates both ticks from free-running counters, with periods of 4 and 6 clocks. Every receiver strobe lasts exactly one clock and is issued between whole frames, so these assumptions always hold. The two tick periods differ, so a frame decoded at the wrong bit period fails its check. This exposes a wrong clock selection.

// File: rtl/echo_loop_ctl.sv
module echo_loop_ctl #(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sync_mode,
  input  logic [1:0]           submode,
  input  logic                 rx_en,
  input  logic                 tx_en,
  input  logic                 rxc_tick,
  input  logic                 txc_tick,
  input  logic                 rx_valid,
  input  logic [DATA_BITS-1:0] rx_data,
  input  logic                 rx_break,
  input  logic                 rx_start,
  input  logic                 rd_strobe,
  output logic [DATA_BITS-1:0] rhr_data,
  output logic                 rx_rdy,
  input  logic                 wr_strobe,
  input  logic [DATA_BITS-1:0] wr_data,
  input  logic                 dset_chg,
  output logic                 tx_rdy,
  output logic                 txemt_dschg,
  output logic                 txd
);

  localparam int FRAME = DATA_BITS + 2;
  localparam int CW    = $clog2(FRAME + 1);

  logic                 echo_on, tx_run, tick, busy;
  logic                 echo_take, cpu_take, load, start;
  logic                 brk_hold, thr_full;
  logic [DATA_BITS-1:0] thr_q;
  logic [FRAME-1:0]     sh;
  logic [CW-1:0]        cnt;

  assign echo_on   = !sync_mode && (submode == 2'b01) && rx_en;
  assign tx_run    = echo_on || tx_en;
  assign tick      = echo_on ? rxc_tick : txc_tick;
  assign busy      = (cnt != '0);

  assign echo_take = echo_on && rx_valid && !(rx_break && brk_hold);
  assign cpu_take  = !echo_on && wr_strobe && tx_en && !thr_full;
  assign load      = echo_take || cpu_take;
  assign start     = tick && tx_run && thr_full && (cnt <= CW'(1));

  assign tx_rdy      = echo_on || (tx_en && !thr_full);
  assign txemt_dschg = dset_chg || (!echo_on && tx_en && !thr_full && !busy);
  assign txd         = busy ? sh[0] : 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n)                   brk_hold <= 1'b0;
    else if (!echo_on || rx_start) brk_hold <= 1'b0;
    else if (rx_valid && rx_break) brk_hold <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thr_full <= 1'b0;
      thr_q    <= '0;
    end else begin
      thr_full <= load || (thr_full && !start);
      if (load) thr_q <= echo_on ? rx_data : wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh  <= '1;
      cnt <= '0;
    end else if (start) begin
      sh  <= {1'b1, thr_q, 1'b0};
      cnt <= CW'(FRAME);
    end else if (busy && tick) begin
      sh  <= {1'b1, sh[FRAME-1:1]};
      cnt <= cnt - CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_rdy   <= 1'b0;
      rhr_data <= '0;
    end else if (!rx_en) begin
      rx_rdy <= 1'b0;
    end else if (rx_valid) begin
      rx_rdy   <= 1'b1;
      rhr_data <= rx_data;
    end else if (rd_strobe) begin
      rx_rdy <= 1'b0;
    end
  end

  a_r3_stop_high: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(txd));

  a_r4_shift_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick) |=> $stable(sh));

  a_r5_echo_runs: assert property (@(posedge clk) disable iff (!rst_n)
    (echo_on && !tx_en && thr_full && !busy && rxc_tick) |=> busy);

  a_r6_cpu_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (echo_on && wr_strobe && !rx_valid) |=> $stable(thr_q));

  a_r7_break_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (echo_on && brk_hold && rx_valid && rx_break && !rx_start) |=> !$rose(thr_full));

  a_r9_rx_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_en) |=> rx_rdy);

endmodule

// File: tb/tb_echo_loop_ctl.sv
module tb_echo_loop_ctl;
  localparam int DB = 8;
  localparam int PRX = 4;
  localparam int PTX = 6;

  logic clk = 0, rst_n = 0;
  logic sync_mode = 0, rx_en = 0, tx_en = 0;
  logic [1:0] submode = 2'b00;
  logic rxc_tick = 0, txc_tick = 0;
  logic rx_valid = 0, rx_break = 0, rx_start = 0, rd_strobe = 0, wr_strobe = 0, dset_chg = 0;
  logic [DB-1:0] rx_data = 0, wr_data = 0, rhr_data;
  logic rx_rdy, tx_rdy, txemt_dschg, txd;
  int checks = 0, errors = 0;

  echo_loop_ctl #(.DATA_BITS(DB)) dut (.*);

  always #2.5 clk = ~clk;

  initial begin
    int rc = 0, tc = 0;
    forever begin
      @(negedge clk);
      rxc_tick <= (rc == 0);
      txc_tick <= (tc == 0);
      rc = (rc + 1) % PRX;
      tc = (tc + 1) % PTX;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rx_char(input logic [DB-1:0] d, input logic brk, input logic with_start);
    if (with_start) begin
      @(negedge clk); rx_start = 1;
      @(negedge clk); rx_start = 0;
    end
    @(negedge clk); rx_valid = 1; rx_data = d; rx_break = brk;
    @(negedge clk); rx_valid = 0; rx_break = 0;
  endtask

  task automatic recv_frame(input int per, output logic [DB-1:0] d, output bit ok);
    bit found = 0;
    d = '0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (txd == 1'b0) begin found = 1; break; end
    end
    for (int i = 0; i < DB; i++) begin
      repeat (per) @(negedge clk);
      d[i] = txd;
    end
    repeat (per) @(negedge clk);
    ok = found && (txd == 1'b1);
    repeat (per) @(negedge clk);
  endtask

  task automatic quiet(input int n, output bit ok);
    ok = 1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (txd !== 1'b1) ok = 0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [DB-1:0] d;
    bit ok;
    repeat (3) @(negedge clk);
    // R1
    chk(txd === 1 && rx_rdy === 0 && tx_rdy === 0 && txemt_dschg === 0, "R1 reset",
        {txd, rx_rdy, tx_rdy, txemt_dschg}, 4'b1000);
    rst_n = 1;
    @(negedge clk);

    // R2: not echo in sync mode, submode 00, or receiver off
    sync_mode = 1; submode = 2'b01; rx_en = 1;
    rx_char(8'h5A, 0, 1); quiet(80, ok); chk(ok, "R2 sync mode", 0, 0);
    sync_mode = 0; submode = 2'b00;
    rx_char(8'h5A, 0, 1); quiet(80, ok); chk(ok, "R2 submode 00", 0, 0);
    submode = 2'b01; rx_en = 0;
    rx_char(8'h5A, 0, 1); quiet(80, ok); chk(ok, "R2 rx disabled", 0, 0);
    chk(rx_rdy === 0, "R9 rx_rdy low with receiver off", rx_rdy, 0);
    rx_en = 1;

    // R3, R4, R5, R9: full sweep in echo with tx_en low
    for (int v = 0; v < 256; v++) begin
      rx_char(DB'(v), 0, 1);
      chk(rx_rdy === 1 && rhr_data === DB'(v), "R9 rhr load", rhr_data, v);
      recv_frame(PRX, d, ok);
      chk(ok && d === DB'(v), "R3/R4/R5 echo frame", d, v);
      if (v % 32 == 0) begin
        @(negedge clk); rd_strobe = 1;
        @(negedge clk); rd_strobe = 0;
        chk(rx_rdy === 0, "R9 read clears", rx_rdy, 0);
      end
    end

    // R6
    chk(tx_rdy === 1, "R6 tx_rdy forced", tx_rdy, 1);
    @(negedge clk); wr_strobe = 1; wr_data = 8'h55;
    @(negedge clk); wr_strobe = 0;
    quiet(80, ok); chk(ok, "R6 cpu write blocked", 0, 0);

    // R8 in echo
    chk(txemt_dschg === 0, "R8 echo empty hidden", txemt_dschg, 0);
    dset_chg = 1; @(negedge clk);
    chk(txemt_dschg === 1, "R8 echo dset", txemt_dschg, 1);
    dset_chg = 0;

    // R7
    rx_char(8'h00, 1, 1);
    recv_frame(PRX, d, ok); chk(ok && d === 8'h00, "R7 first break echoed", d, 0);
    rx_char(8'h00, 1, 0); quiet(60, ok); chk(ok, "R7 second break dropped", 0, 0);
    rx_char(8'h00, 1, 0); quiet(60, ok); chk(ok, "R7 third break dropped", 0, 0);
    rx_char(8'hA5, 0, 1);
    recv_frame(PRX, d, ok); chk(ok && d === 8'hA5, "R7 echo resumes", d, 8'hA5);

    // R10, R4, R8 in normal mode
    submode = 2'b00; tx_en = 1;
    @(negedge clk);
    chk(tx_rdy === 1 && txemt_dschg === 1, "R8 normal empty", {tx_rdy, txemt_dschg}, 2'b11);
    wr_strobe = 1; wr_data = 8'h3C;
    @(negedge clk); wr_strobe = 0;
    chk(tx_rdy === 0, "R10 tx_rdy drops", tx_rdy, 0);
    recv_frame(PTX, d, ok); chk(ok && d === 8'h3C, "R10/R4 normal frame", d, 8'h3C);
    @(negedge clk); wr_strobe = 1; wr_data = 8'hC3;
    @(negedge clk); wr_strobe = 0;
    recv_frame(PTX, d, ok); chk(ok && d === 8'hC3, "R10 second frame", d, 8'hC3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule